// File: doc/BRIEF.md
# Packet Read Data-Out Engine

This block moves a response that is already sitting in a buffer RAM out to the host. A start strobe gives it a byte length, a per-DRQ block size and a transfer-mode select. In programmed-I/O mode the host takes the data one 16-bit word per data-register read. In DMA mode a requester asks for a byte count, and the engine grants no more than what is left. It then streams the granted words, one per cycle, to a write port.

While the transfer runs, the engine keeps the status, interrupt-reason and byte-count registers current. It pulses an interrupt at the points where the host must act. It pulses a separate completion event when a DMA transfer has drained the buffer. Filling the buffer, decoding commands and host bus timing belong to neighbouring blocks.

Top module: `pkt_read_streamer`

## Requirements
- R1: After reset the status register reads 0x50, the interrupt-reason register reads 0x00, both byte-count registers read 0x00, and no interrupt, acknowledge, completion or write pulse is present.
- R2: A start in PIO mode sets the status register to 0x48 and the interrupt-reason register to 0x02 (bit 1 flags device-to-host I/O). It loads the byte length into the byte-count registers, with the low byte in the mid register and bits 15:8 in the high register. It pulses the interrupt for one cycle in the cycle after the start.
- R3: A start in DMA mode sets the status register to 0xD0 and the interrupt-reason register to 0x02, and it raises no interrupt.
- R4: Each PIO data read returns, in the same cycle, the buffer word at byte offset/2. The offset starts at 0 and advances by 2 after each read.
- R5: A reload counter starts at the block size and drops by 2 on each PIO read. A read that finds it at 2 or below reloads it from the block size and pulses the interrupt in the next cycle. With an even block size B, this happens after every B/2 reads.
- R6: The PIO read that brings the offset to or past the length returns the engine to idle, sets the status register to 0x40 (DRQ cleared), and pulses the interrupt exactly once, even when a block boundary falls on the same read.
- R7: A DMA request of N bytes is acknowledged in the next cycle with a granted count of min(N, length − offset). The offset advances by that count. Starting at the current word, ceil(count/2) words are written out, one per cycle, with the first write in the acknowledge cycle.
- R8: One cycle after the last word of the grant that empties the buffer has been written, the status register becomes 0x50, and the interrupt and the completion event pulse together in that one cycle.
- R9: A PIO read outside PIO mode returns 0 and changes nothing. A DMA request outside DMA mode, or while words are still streaming, is acknowledged with a count of 0 and moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (one-cycle strobe) |
| start_len_i | input | LEN_W | Transfer length in bytes |
| start_blk_i | input | LEN_W | PIO bytes per interrupt block |
| start_dma_i | input | 1 | 1 selects DMA, 0 selects PIO |
| pio_rd_i | input | 1 | Host data-register read strobe |
| pio_data_o | output | 16 | Word returned for the PIO read |
| dma_req_i | input | 1 | DMA request strobe |
| dma_len_i | input | LEN_W | Bytes requested |
| dma_ack_o | output | 1 | Request acknowledge pulse |
| dma_cnt_o | output | LEN_W | Bytes granted, valid with the acknowledge |
| dma_wr_o | output | 1 | DMA word write strobe |
| dma_wdata_o | output | 16 | DMA word data |
| buf_addr_o | output | ADDR_W | Buffer RAM word address |
| buf_data_i | input | 16 | Buffer RAM read data (combinational) |
| status_o | output | 8 | Status register |
| count_o | output | 8 | Interrupt-reason register |
| bcnt_lo_o | output | 8 | Byte count low (LBA mid) |
| bcnt_hi_o | output | 8 | Byte count high (LBA high) |
| irq_o | output | 1 | Interrupt pulse |
| dma_done_o | output | 1 | DMA completion pulse |

## Verification
Two events can coincide on the PIO path: the end of a block and the end of the transfer can fall on the same data read. The bench provokes this by sweeping lengths that are whole multiples of each block size, alongside lengths that are not. For every combination it counts interrupt pulses and compares the total against the arithmetic expectation: one pulse for the start, one for each interior block boundary, and exactly one for the final read. The final status value is checked for every combination as well.

On the DMA side, the bench sends a second request in the cycle right after each acknowledge, while words are still streaming. That request must be granted zero bytes without disturbing the data stream.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PIO, ST_DMA} rdx_state_e;
  localparam logic [7:0] STAT_RESET   = 8'h50;
  localparam logic [7:0] STAT_PIO     = 8'h48;
  localparam logic [7:0] STAT_PIO_END = 8'h40;
  localparam logic [7:0] STAT_DMA     = 8'hD0;
  localparam logic [7:0] STAT_DMA_END = 8'h50;
  localparam logic [7:0] REASON_IO    = 8'h02;
endpackage

// File: rtl/rdx_blk_cnt.sv
module rdx_blk_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] size_i,
  input  logic         step_i,
  output logic         wrap_o
);
  localparam logic [W-1:0] STEP = W'(2);

  logic [W-1:0] size_q, cnt_q;
  logic         at_edge;

  assign at_edge = (cnt_q <= STEP);
  assign wrap_o  = step_i && at_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      size_q <= size_i;
      cnt_q  <= size_i;
    end else if (step_i) begin
      cnt_q <= at_edge ? size_q : cnt_q - STEP;
    end
  end

  // R5: the counter never exceeds the block size it reloads from
  p_blk_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= size_q);
endmodule

// File: rtl/rdx_dma_mover.sv
module rdx_dma_mover #(
  parameter int AW = 6,
  parameter int LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] words_i,
  output logic [AW-1:0] addr_o,
  output logic          wr_o,
  output logic          busy_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q;

  assign busy_o = (left_q != '0);
  assign wr_o   = busy_o;
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      left_q <= words_i;
    end else if (busy_o) begin
      addr_q <= addr_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  // R7: consecutive streamed words come from consecutive addresses
  p_mover_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !load_i |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/pkt_read_streamer.sv
module pkt_read_streamer
  import rdx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic [LEN_W-1:0]  start_blk_i,
  input  logic              start_dma_i,
  input  logic              pio_rd_i,
  output logic [15:0]       pio_data_o,
  input  logic              dma_req_i,
  input  logic [LEN_W-1:0]  dma_len_i,
  output logic              dma_ack_o,
  output logic [LEN_W-1:0]  dma_cnt_o,
  output logic              dma_wr_o,
  output logic [15:0]       dma_wdata_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [15:0]       buf_data_i,
  output logic [7:0]        status_o,
  output logic [7:0]        count_o,
  output logic [7:0]        bcnt_lo_o,
  output logic [7:0]        bcnt_hi_o,
  output logic              irq_o,
  output logic              dma_done_o
);
  localparam int OFF_W = LEN_W + 1;

  rdx_state_e         st_q;
  logic [OFF_W-1:0]   off_q, len_ext, remain, grant, off_step;
  logic [LEN_W-1:0]   len_q;
  logic [7:0]         status_q, count_q, bcnt_lo_q, bcnt_hi_q;
  logic               irq_q, done_q, ack_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               pio_hit, pio_end, blk_wrap;
  logic               dma_ok, dma_fin, mv_busy, mv_wr, mv_load;
  logic [ADDR_W-1:0]  mv_addr;
  logic [LEN_W-1:0]   mv_words;

  assign len_ext  = {1'b0, len_q};
  assign remain   = (off_q < len_ext) ? len_ext - off_q : '0;
  assign grant    = ({1'b0, dma_len_i} < remain) ? {1'b0, dma_len_i} : remain;
  assign off_step = off_q + OFF_W'(2);

  assign pio_hit = pio_rd_i && (st_q == ST_PIO);
  assign pio_end = pio_hit && (off_step >= len_ext);
  assign dma_ok  = dma_req_i && (st_q == ST_DMA) && !mv_busy && (remain != '0);
  assign dma_fin = (st_q == ST_DMA) && !mv_busy && (remain == '0);

  // a new start flushes any stream still in flight
  assign mv_load  = start_i || dma_ok;
  assign mv_words = start_i ? '0 : LEN_W'((grant + OFF_W'(1)) >> 1);

  rdx_blk_cnt #(.W(LEN_W)) u_blk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i && !start_dma_i),
    .size_i (start_blk_i),
    .step_i (pio_hit && !start_i),
    .wrap_o (blk_wrap)
  );

  rdx_dma_mover #(.AW(ADDR_W), .LW(LEN_W)) u_mover (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (mv_load),
    .base_i  (off_q[ADDR_W:1]),
    .words_i (mv_words),
    .addr_o  (mv_addr),
    .wr_o    (mv_wr),
    .busy_o  (mv_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      off_q     <= '0;
      len_q     <= '0;
      status_q  <= STAT_RESET;
      count_q   <= '0;
      bcnt_lo_q <= '0;
      bcnt_hi_q <= '0;
      irq_q     <= 1'b0;
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      ack_q  <= dma_req_i;
      cnt_q  <= '0;
      if (start_i) begin
        len_q   <= start_len_i;
        off_q   <= '0;
        count_q <= REASON_IO;
        if (start_dma_i) begin
          st_q     <= ST_DMA;
          status_q <= STAT_DMA;
        end else begin
          st_q      <= ST_PIO;
          status_q  <= STAT_PIO;
          bcnt_lo_q <= start_len_i[7:0];
          bcnt_hi_q <= 8'(start_len_i >> 8);
          irq_q     <= 1'b1;
        end
      end else begin
        if (pio_hit) begin
          off_q <= off_step;
          if (pio_end) begin
            st_q     <= ST_IDLE;
            status_q <= STAT_PIO_END;
            irq_q    <= 1'b1;
          end else if (blk_wrap) begin
            irq_q <= 1'b1;
          end
        end
        if (dma_ok) begin
          off_q <= off_q + grant;
          cnt_q <= LEN_W'(grant);
        end
        if (dma_fin) begin
          st_q     <= ST_IDLE;
          status_q <= STAT_DMA_END;
          irq_q    <= 1'b1;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign buf_addr_o  = mv_busy ? mv_addr : off_q[ADDR_W:1];
  assign pio_data_o  = pio_hit ? buf_data_i : 16'h0000;
  assign dma_wr_o    = mv_wr;
  assign dma_wdata_o = buf_data_i;
  assign dma_ack_o   = ack_q;
  assign dma_cnt_o   = cnt_q;
  assign status_o    = status_q;
  assign count_o     = count_q;
  assign bcnt_lo_o   = bcnt_lo_q;
  assign bcnt_hi_o   = bcnt_hi_q;
  assign irq_o       = irq_q;
  assign dma_done_o  = done_q;

  p_pio_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !start_dma_i |=> irq_o && status_o == 8'h48 && count_o == 8'h02);

  p_dma_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && start_dma_i |=> !irq_o && status_o == 8'hD0);

  p_grant_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i |=> dma_ack_o && dma_cnt_o <= $past(dma_len_i));

  p_done_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_o |-> irq_o && status_o == 8'h50);

  p_pio_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_rd_i && status_o != 8'h48 |-> pio_data_o == 16'h0000);

  p_wr_in_dma_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_wr_o |-> status_o == 8'hD0);
endmodule

// File: tb/pkt_read_streamer_tb_top.sv
module pkt_read_streamer_tb_top;
  localparam int AW = 6;
  localparam int LW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [LW-1:0] start_len_i = '0;
  logic [LW-1:0] start_blk_i = '0;
  logic          start_dma_i = 1'b0;
  logic          pio_rd_i = 1'b0;
  logic [15:0]   pio_data_o;
  logic          dma_req_i = 1'b0;
  logic [LW-1:0] dma_len_i = '0;
  logic          dma_ack_o;
  logic [LW-1:0] dma_cnt_o;
  logic          dma_wr_o;
  logic [15:0]   dma_wdata_o;
  logic [AW-1:0] buf_addr_o;
  logic [15:0]   buf_data_i;
  logic [7:0]    status_o, count_o, bcnt_lo_o, bcnt_hi_o;
  logic          irq_o, dma_done_o;

  int checks = 0;
  int fails  = 0;
  int irq_seen = 0, done_seen = 0, words_seen = 0, data_bad = 0;
  int dma_addr = 0;
  int dma_base = 0;

  always #5 clk_i = ~clk_i;

  function automatic logic [15:0] fword(int a);
    return 16'hC300 ^ (16'(a) * 16'h0101);
  endfunction

  assign buf_data_i = fword(int'(buf_addr_o));

  pkt_read_streamer #(.ADDR_W(AW), .LEN_W(LW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_len_i(start_len_i),
    .start_blk_i(start_blk_i), .start_dma_i(start_dma_i), .pio_rd_i(pio_rd_i),
    .pio_data_o(pio_data_o), .dma_req_i(dma_req_i), .dma_len_i(dma_len_i),
    .dma_ack_o(dma_ack_o), .dma_cnt_o(dma_cnt_o), .dma_wr_o(dma_wr_o),
    .dma_wdata_o(dma_wdata_o), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
    .status_o(status_o), .count_o(count_o), .bcnt_lo_o(bcnt_lo_o),
    .bcnt_hi_o(bcnt_hi_o), .irq_o(irq_o), .dma_done_o(dma_done_o)
  );

  // monitor: counts pulses and checks the DMA word stream, relative to dma_base
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (irq_o) irq_seen++;
      if (dma_done_o) done_seen++;
      if (dma_wr_o) begin
        if (dma_wdata_o != fword(dma_addr - dma_base + dma_base)) data_bad++;
        dma_addr++;
        words_seen++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input int len, input int blk, input bit dma);
    @(negedge clk_i);
    start_i = 1'b1; start_len_i = LW'(len); start_blk_i = LW'(blk); start_dma_i = dma;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic pio_read(output logic [15:0] val);
    pio_rd_i = 1'b1;
    #1 val = pio_data_o;
    @(posedge clk_i);
    @(negedge clk_i);
    pio_rd_i = 1'b0;
  endtask

  task automatic run_pio(input int len, input int blk);
    int irq0, n, exp_irq, bad;
    logic [15:0] v;
    irq0 = irq_seen;
    do_start(len, blk, 1'b0);
    chk(status_o == 8'h48 && count_o == 8'h02, "R2 status/reason", {status_o, count_o}, 16'h4802);
    chk(bcnt_lo_o == 8'(len) && bcnt_hi_o == 8'(len >> 8), "R2 byte count",
        {bcnt_hi_o, bcnt_lo_o}, len);
    chk(irq_o == 1'b1, "R2 start irq", irq_o, 1);
    n = (len + 1) / 2;
    exp_irq = 1;
    bad = 0;
    for (int k = 1; k <= n; k++) begin
      pio_read(v);
      if (v != fword(k - 1)) bad++;
      if (k == n || (k % (blk / 2)) == 0) exp_irq++;
    end
    chk(bad == 0, "R4 PIO word order", bad, 0);
    repeat (2) @(negedge clk_i);
    // R5 and R6: block interrupts plus exactly one end interrupt
    chk(irq_seen - irq0 == exp_irq, "R5/R6 irq count", irq_seen - irq0, exp_irq);
    chk(status_o == 8'h40, "R6 end status", status_o, 8'h40);
    // R9: a read in idle returns zero and raises nothing
    irq0 = irq_seen;
    pio_read(v);
    repeat (2) @(negedge clk_i);
    chk(v == 16'h0 && status_o == 8'h40 && irq_seen == irq0, "R9 idle PIO read", v, 0);
  endtask

  task automatic dma_request(input int n, input int rem, output int got);
    int exp;
    exp = (n < rem) ? n : rem;
    dma_req_i = 1'b1; dma_len_i = LW'(n);
    @(posedge clk_i);
    @(negedge clk_i);
    got = int'(dma_cnt_o);
    chk(dma_ack_o && got == exp, "R7 grant", got, exp);
    // second request while streaming: must be refused
    dma_len_i = LW'(2);
    @(posedge clk_i);
    @(negedge clk_i);
    dma_req_i = 1'b0;
    chk(dma_ack_o && dma_cnt_o == '0, "R9 busy request", int'(dma_cnt_o), 0);
    while (dma_wr_o) @(negedge clk_i);
  endtask

  task automatic run_dma(input int len, input int req);
    int irq0, done0, w0, bad0, rem, got, exp_words;
    logic [15:0] v;
    irq0 = irq_seen; done0 = done_seen; w0 = words_seen; bad0 = data_bad;
    dma_addr = 0; dma_base = 0;
    do_start(len, 0, 1'b1);
    chk(status_o == 8'hD0 && count_o == 8'h02, "R3 status", {status_o, count_o}, 16'hD002);
    pio_read(v);
    chk(v == 16'h0, "R9 PIO read in DMA mode", v, 0);
    repeat (2) @(negedge clk_i);
    chk(irq_seen == irq0, "R3 no start irq", irq_seen - irq0, 0);
    rem = len;
    exp_words = 0;
    while (rem > 0) begin
      dma_request(req, rem, got);
      if (got == 0) break;
      exp_words += (got + 1) / 2;
      rem -= got;
    end
    repeat (3) @(negedge clk_i);
    chk(words_seen - w0 == exp_words && data_bad == bad0, "R7 stream",
        words_seen - w0, exp_words);
    chk(done_seen - done0 == 1 && irq_seen - irq0 == 1, "R8 completion pulses",
        (done_seen - done0) * 16 + irq_seen - irq0, 16'h11);
    chk(status_o == 8'h50, "R8 end status", status_o, 8'h50);
    // R9: request in idle acks with zero and moves nothing
    w0 = words_seen;
    dma_req_i = 1'b1; dma_len_i = LW'(8);
    @(posedge clk_i);
    @(negedge clk_i);
    dma_req_i = 1'b0;
    chk(dma_ack_o && dma_cnt_o == '0, "R9 idle request", int'(dma_cnt_o), 0);
    repeat (2) @(negedge clk_i);
    chk(words_seen == w0, "R9 idle no words", words_seen - w0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(status_o == 8'h50 && count_o == 8'h00 && bcnt_lo_o == 8'h00 && bcnt_hi_o == 8'h00,
        "R1 reset registers", status_o, 8'h50);
    chk(!irq_o && !dma_done_o && !dma_ack_o && !dma_wr_o, "R1 reset pulses",
        {irq_o, dma_done_o, dma_ack_o, dma_wr_o}, 0);
    for (int b = 2; b <= 8; b += 2) begin
      for (int l = 2; l <= 24; l += 2) run_pio(l, b);
      run_pio(5, b);
      run_pio(13, b);
    end
    run_pio(300 % 128, 4);
    run_dma(8, 4);
    run_dma(8, 100);
    run_dma(12, 6);
    run_dma(20, 6);
    run_dma(20, 4);
    run_dma(24, 100);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule